// File: doc/BRIEF.md
# Serial Receiver with Fill-Level Flow Control

This block turns asynchronous serial frames on a single input line into characters and queues them for a host. It runs from the system clock and samples the line only on a strobe that pulses sixteen times per bit period. An 8-bit format byte sets the word length, the parity mode and whether the parity bit is checked or passed upward. Each character enters a small first-in-first-out queue together with its own parity and framing flags. The host reads the character at the head and pops it with a strobe.

A request-to-send output, active low, tells the far end when to pause. It goes high as soon as the number of queued characters reaches a 4-bit trigger level, and it returns low once the queue drains below that level. A character that arrives while the queue is full is lost, and a sticky overrun output reports the loss until reset. The format byte must be held steady while a frame is being received.

Top module: `uart_rx_flow`

## Requirements
- R1: Format bits [1:0] set the word length: 00, 01, 10 and 11 give 5, 6, 7 and 8 data bits. Data bits arrive LSB first and are stored from bit 0 upward. All stored bits above the word are 0, unless R6 applies.
- R2: A low level seen on a baud strobe while idle starts a frame. The frame is kept only if the line is still low on the 8th strobe after that one. If it is not, nothing is queued. Every later bit is sampled 16 strobes after the previous sample.
- R3: A parity bit follows the data only when format bit [3] is 1. When bit [3] is 0, the stop bit comes right after the last data bit and the parity flag is 0.
- R4: With bit [3]=1, bit [7]=0 and bit [5]=0, the parity flag is set when the data plus parity bit hold an even number of ones (bit [4]=0) or an odd number of ones (bit [4]=1).
- R5: With bit [3]=1, bit [7]=0 and bit [5]=1, the parity bit must be 1 when bit [4]=0 and 0 when bit [4]=1. Any other value sets the parity flag.
- R6: With bits [3] and [7] both 1, the parity bit is not checked and the parity flag is 0. The received parity bit is stored at the bit position just above the last data bit.
- R7: Only the first stop bit is checked. If it is sampled low, the framing flag is stored with the character.
- R8: The queue holds 16 characters in arrival order. fill_o gives the count. The head entry is shown on the data and flag outputs. A pop strobe removes the head, and a pop while the queue is empty has no effect.
- R9: A character completed while the queue is full and no pop is applied is dropped, and overrun_o goes high and stays high until reset. A pop in the same cycle makes room for the character.
- R10: nrts_o is 1 whenever fill_o is at least rts_level_i and 0 otherwise. With a level of 0 it is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | Strobe at 16 times the bit rate |
| fmt_i | input | 8 | Format byte: length, parity enable, parity sense, forced parity, raw parity |
| rts_level_i | input | 4 | Queue count that de-asserts request-to-send |
| pop_i | input | 1 | Removes the head character |
| rd_data_o | output | 9 | Head character, with the raw parity bit when R6 applies |
| rd_perr_o | output | 1 | Parity flag of the head character |
| rd_ferr_o | output | 1 | Framing flag of the head character |
| fill_o | output | 5 | Number of queued characters |
| overrun_o | output | 1 | Sticky flag for a lost character |
| nrts_o | output | 1 | Request-to-send, active low |

## Verification
The bench builds the block with its default queue depth of 16. A full queue is then reached after 16 frames, so the drop path, the sticky overrun flag and a push that coincides with a pop all occur within a short run. The strobe is driven both on every clock and on every third clock. This shows that frame timing follows the strobe and not the clock. The trigger level is changed while the queue fills and drains, and is set to 0, so request-to-send is seen switching at both edges of the threshold.

// File: rtl/uart_rx_flow.sv
module uart_rx_flow #(
  parameter int DEPTH = 16,
  parameter int LW    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  input  logic          tick16_i,
  input  logic [7:0]    fmt_i,
  input  logic [LW-1:0] rts_level_i,
  input  logic          pop_i,
  output logic [8:0]    rd_data_o,
  output logic          rd_perr_o,
  output logic          rd_ferr_o,
  output logic [CW-1:0] fill_o,
  output logic          overrun_o,
  output logic          nrts_o
);
  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} st_t;

  st_t         st;
  logic [3:0]  tcnt;
  logic [2:0]  bidx;
  logic [7:0]  shreg;
  logic        pbit;
  logic [10:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic        ovr;

  logic [3:0]  nbits;
  logic        last, samp, push, do_push, do_pop, perr;
  logic [8:0]  word;

  assign nbits = 4'd5 + {2'b00, fmt_i[1:0]};
  assign last  = ({1'b0, bidx} == nbits - 4'd1);
  assign samp  = tick16_i && (st != IDLE) && (tcnt == ((st == START) ? 4'd7 : 4'd15));
  assign push  = (st == STOP) && samp;

  assign word  = {1'b0, shreg} | ((fmt_i[3] && fmt_i[7]) ? (9'(pbit) << nbits) : 9'd0);
  assign perr  = fmt_i[3] && !fmt_i[7] &&
                 ((fmt_i[5] ? pbit : (^shreg ^ pbit)) == fmt_i[4]);

  assign do_pop  = pop_i && (cnt != '0);
  assign do_push = push && ((cnt != CW'(DEPTH)) || do_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else if (tick16_i) begin
      if (st == IDLE) begin
        if (!rx_i) begin
          st   <= START;
          tcnt <= '0;
        end
      end else if (!samp) begin
        tcnt <= tcnt + 4'd1;
      end else begin
        tcnt <= '0;
        case (st)
          START: begin
            st    <= rx_i ? IDLE : DATA;
            bidx  <= '0;
            shreg <= '0;
          end
          DATA: begin
            shreg[bidx] <= rx_i;
            bidx <= bidx + 3'd1;
            if (last) st <= fmt_i[3] ? PAR : STOP;
          end
          PAR: begin
            pbit <= rx_i;
            st   <= STOP;
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= {~rx_i, perr, word};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovr <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
      if (push && !do_push) ovr <= 1'b1;
    end
  end

  assign rd_data_o = mem[rp][8:0];
  assign rd_perr_o = mem[rp][9];
  assign rd_ferr_o = mem[rp][10];
  assign fill_o    = cnt;
  assign overrun_o = ovr;
  assign nrts_o    = (cnt >= CW'(rts_level_i));
endmodule

module uart_rx_flow_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          pop,
  input logic [LW-1:0] level,
  input logic [CW-1:0] fill,
  input logic          nrts,
  input logic          ovr
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) fill <= CW'(DEPTH)); // R8
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == $past(fill)) || (fill == $past(fill) + CW'(1)) || (fill + CW'(1) == $past(fill))); // R8
  AST_PUSH_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (fill > $past(fill)) |-> $past(tick)); // R2
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovr |=> ovr); // R9
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CW'(DEPTH) && !pop) |=> (fill == CW'(DEPTH))); // R9
  AST_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (level == '0) |-> nrts); // R10
  AST_EMPTY_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0 && level != '0) |-> !nrts); // R10
endmodule

bind uart_rx_flow uart_rx_flow_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick16_i), .pop(pop_i), .level(rts_level_i),
  .fill(fill_o), .nrts(nrts_o), .ovr(overrun_o)
);

// File: tb/uart_rx_flow_tb.sv
module uart_rx_flow_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_i = 1'b1, tick16_i = 1'b0, pop_i = 1'b0;
  logic [7:0] fmt_i = 8'h03;
  logic [3:0] rts_level_i = 4'd4;
  logic [8:0] rd_data_o;
  logic rd_perr_o, rd_ferr_o, overrun_o, nrts_o;
  logic [4:0] fill_o;

  uart_rx_flow u_dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, tdiv = 1, div = 0;
  logic [10:0] q[$];
  logic [10:0] exp_entry;
  bit line = 1, push_now = 0, pop_req = 0, ovr_m = 0;
  string tag = "R8";

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", r, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic cycle();
    @(negedge clk);
    tick16_i = (div == 0);
    div = (div + 1) % tdiv;
    rx_i = line;
    pop_i = pop_req;
    @(posedge clk);
    cyc++;
    if (pop_i && q.size() > 0) void'(q.pop_front());
    if (push_now) begin
      if (q.size() < 16) q.push_back(exp_entry);
      else ovr_m = 1;
    end
    #1;
    chk("R8", int'(fill_o), q.size());
    chk("R10", int'(nrts_o), int'(q.size() >= int'(rts_level_i)));
    chk("R9", int'(overrun_o), int'(ovr_m));
    if (q.size() > 0) begin
      chk(tag, int'(rd_data_o), int'(q[0][8:0]));
      chk(tag, int'(rd_perr_o), int'(q[0][9]));
      chk("R7", int'(rd_ferr_o), int'(q[0][10]));
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      finish_run();
    end
  endtask

  task automatic idle(int n);
    line = 1;
    repeat (n) cycle();
  endtask

  task automatic pop1();
    pop_req = 1; cycle(); pop_req = 0;
  endtask

  function automatic bit good_par(logic [7:0] d);
    int nb = 5 + int'(fmt_i[1:0]);
    int ones = 0;
    for (int k = 0; k < nb; k++) ones += int'(d[k]);
    if (fmt_i[5]) return !fmt_i[4];
    return fmt_i[4] ? bit'(ones % 2) : bit'((ones + 1) % 2);
  endfunction

  task automatic send(logic [7:0] d, bit p, bit stopv, bit pop_on_push = 0);
    int nb = 5 + int'(fmt_i[1:0]);
    int stopi = 1 + nb + int'(fmt_i[3]);
    logic bits[12];
    logic [8:0] w = '0;
    int ti = -1;
    bits[0] = 0;
    for (int k = 0; k < nb; k++) begin bits[1 + k] = d[k]; w[k] = d[k]; end
    if (fmt_i[3]) bits[1 + nb] = p;
    bits[stopi] = stopv;
    if (fmt_i[3] && fmt_i[7]) w[nb] = p;
    exp_entry = {!stopv, fmt_i[3] && !fmt_i[7] && (p != good_par(d)), w};
    line = 0;
    while (ti < 16 * stopi + 15) begin
      bit tk = (div == 0);
      if (tk) begin ti++; line = bits[ti / 16]; end
      push_now = tk && (ti == 16 * stopi + 8);
      pop_req = pop_on_push && push_now;
      cycle();
      push_now = 0; pop_req = 0;
    end
    line = 1;
    idle(3 * tdiv);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8", int'(fill_o), 0);
    chk("R10", int'(nrts_o), 0);
    chk("R9", int'(overrun_o), 0);
    rst_n = 1;
    idle(4);

    tag = "R1"; fmt_i = 8'h03;
    send(8'hA5, 0, 1); send(8'h3C, 0, 1);
    fmt_i = 8'h00; send(8'h15, 0, 1); send(8'h1F, 0, 1);
    pop1(); pop1(); pop1(); pop1(); pop1();

    tag = "R4"; fmt_i = 8'h0A;
    send(8'h55, good_par(8'h55), 1); send(8'h55, !good_par(8'h55), 1);
    fmt_i = 8'h1A;
    send(8'h07, good_par(8'h07), 1); send(8'h07, !good_par(8'h07), 1);
    repeat (4) pop1();

    tag = "R5"; tdiv = 3; fmt_i = 8'h2B;
    send(8'h81, 1, 1); send(8'h81, 0, 1);
    fmt_i = 8'h3B;
    send(8'hFF, 0, 1); send(8'hFF, 1, 1);
    repeat (4) pop1();

    tag = "R6"; fmt_i = 8'h89;
    send(8'h2A, 1, 1); send(8'h2A, 0, 1);
    fmt_i = 8'h9B; send(8'h00, 1, 1);
    tag = "R3"; fmt_i = 8'h32; send(8'h7F, 1, 1);
    repeat (5) pop1();

    tag = "R7"; tdiv = 1; fmt_i = 8'h03;
    send(8'h5A, 0, 0);
    idle(20);
    pop1(); pop1();

    tag = "R2"; line = 0;
    repeat (5) cycle();
    idle(30);
    chk("R2", int'(fill_o), 0);
    send(8'hC3, 0, 1);
    pop1();

    tag = "R10"; rts_level_i = 4'd3;
    for (int i = 0; i < 16; i++) send(8'(i * 7 + 1), 0, 1);
    chk("R8", int'(fill_o), 16);
    tag = "R9";
    send(8'hEE, 0, 1);
    chk("R9", int'(overrun_o), 1);
    send(8'hDD, 0, 1, 1);
    chk("R9", int'(fill_o), 16);
    rts_level_i = 4'd0;
    for (int i = 0; i < 14; i++) pop1();
    rts_level_i = 4'd2;
    pop1(); pop1(); pop1();
    chk("R10", int'(nrts_o), 0);
    rts_level_i = 4'd0; idle(2);
    chk("R10", int'(nrts_o), 1);
    finish_run();
  end
endmodule